// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches a group of input pins and turns activity on each of them into a per-channel interrupt request line. Every channel has its own mode. The mode makes the channel silent, or sensitive to rising edges, falling edges or both edges, or sensitive to a low or high pin level. Pins are asynchronous to the block clock. Each one passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with the value one cycle earlier.

Each channel keeps three pieces of state. Two are sticky flags, one recording a rising edge and one recording a falling edge. The third is a request status that drives the channel's interrupt line. Software reaches this state through a plain single-cycle register port. Reads are combinational from the address. A write takes effect at the next clock edge. The status and flag registers clear a bit when a 1 is written to it, so a mask of all ones clears every channel in one write. In level mode the status tracks the pin level and cannot be cleared by software.

Top module: `pinirq_detector`

## Requirements
- R1: After reset every interrupt line is 0, and the status, rise-flag, fall-flag and mode registers all read 0.
- R2: The mode register of channel i is at address 8+i. Bit 4 selects level sensing (1) or edge sensing (0). Bit 0 enables rising edges. Bit 1 enables falling edges in edge mode, or selects high level in level mode. The other bits are not stored and read 0.
- R3: In mode 0x01 a rising pin edge sets the channel status, and the interrupt line goes high three clock edges after the pin changes. A falling edge does not set the status.
- R4: In mode 0x02 only a falling edge sets the status. In mode 0x03 either edge sets it.
- R5: In edge mode, an enabled rising edge sets bit i of the rise-flag register (address 1), and an enabled falling edge sets bit i of the fall-flag register (address 2). Each flag stays set until a 1 is written to its bit.
- R6: Status is at address 0, one bit per channel. For a channel in edge mode, writing 1 to its bit clears its status. Writing 0xFF clears all edge channels at once.
- R7: In mode 0x10 the status equals the inverted synchronised pin. In mode 0x12 it equals the synchronised pin. Writing the status register has no effect on a level channel.
- R8: In mode 0x00 the channel's interrupt stays low and its flags do not set, whatever the pin does.
- R9: If a detected edge and a clear write for the same bit fall in the same cycle, the edge wins and the bit stays set. This holds for the status and for both flags.
- R10: Writing a channel's mode register clears that channel's status in the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | CH | Asynchronous pins, one per channel |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| irq_o | output | CH | Interrupt request per channel |

## Verification
The assertions assume that pins change slowly compared with the clock, so that the synchroniser delivers a clean level. They also assume that register writes are single-cycle strobes with a stable address and data. The bench holds every pin for at least three clock edges. It drives each write for exactly one rising edge from the falling edge before it. The deliberate same-cycle collision of an edge and a clear is placed by counting the synchroniser stages rather than left to chance.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  // Mode field bit positions within the mode register
  localparam int MODE_LVL_BIT = 4;
  localparam int MODE_B1_BIT  = 1;
  localparam int MODE_B0_BIT  = 0;

  // Register addresses
  localparam int ADDR_STAT = 0;
  localparam int ADDR_RISE = 1;
  localparam int ADDR_FALL = 2;
  localparam int ADDR_MODE = 8;

  typedef struct packed {
    logic lvl;  // 1 = level sensing
    logic b1;   // fall enable (edge) / high select (level)
    logic b0;   // rise enable (edge)
  } chan_mode_t;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] pin_i,
  output logic [CH-1:0] lvl_o,
  output logic [CH-1:0] rise_o,
  output logic [CH-1:0] fall_o
);
  logic [CH-1:0] st1_q, st2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q  <= '0;
      st2_q  <= '0;
      prev_q <= '0;
    end else begin
      st1_q  <= pin_i;
      st2_q  <= st1_q;
      prev_q <= st2_q;
    end
  end

  assign lvl_o  = st2_q;
  assign rise_o = st2_q & ~prev_q;
  assign fall_o = ~st2_q & prev_q;
endmodule

// File: rtl/pinirq_cfg.sv
module pinirq_cfg
  import pinirq_pkg::*;
#(
  parameter int CH     = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  chan_mode_t            wmode_i,
  output chan_mode_t [CH-1:0]   mode_o,
  output logic [CH-1:0]         mode_wr_o
);
  for (genvar g = 0; g < CH; g++) begin : g_mode
    assign mode_wr_o[g] = wr_i && (addr_i == ADDR_W'(ADDR_MODE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mode_o[g] <= '0;
      else if (mode_wr_o[g]) mode_o[g] <= wmode_i;
    end
  end
endmodule

// File: rtl/pinirq_chan.sv
module pinirq_chan
  import pinirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  chan_mode_t mode_i,
  input  logic       mode_wr_i,
  input  logic       clr_stat_i,
  input  logic       clr_rise_i,
  input  logic       clr_fall_i,
  output logic       stat_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic rise_hit, fall_hit, stat_d, rise_d, fall_d;

  assign rise_hit = !mode_i.lvl && mode_i.b0 && rise_i;
  assign fall_hit = !mode_i.lvl && mode_i.b1 && fall_i;

  always_comb begin
    if (mode_wr_i)                   stat_d = 1'b0;
    else if (mode_i.lvl)             stat_d = mode_i.b1 ? lvl_i : !lvl_i;
    else if (!mode_i.b0 && !mode_i.b1) stat_d = 1'b0;
    else if (rise_hit || fall_hit)   stat_d = 1'b1;
    else if (clr_stat_i)             stat_d = 1'b0;
    else                             stat_d = stat_o;

    if (rise_hit)        rise_d = 1'b1;
    else if (clr_rise_i) rise_d = 1'b0;
    else                 rise_d = rise_o;

    if (fall_hit)        fall_d = 1'b1;
    else if (clr_fall_i) fall_d = 1'b0;
    else                 fall_d = fall_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      stat_o <= stat_d;
      rise_o <= rise_d;
      fall_o <= fall_d;
    end
  end
endmodule

// File: rtl/pinirq_detector.sv
module pinirq_detector
  import pinirq_pkg::*;
#(
  parameter int CH     = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     pin_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CH-1:0]     irq_o
);
  logic [CH-1:0] lvl_s, rise_evt, fall_evt;
  logic [CH-1:0] stat_q, rise_q, fall_q, mode_wr;
  logic [CH-1:0] clr_stat, clr_rise, clr_fall;
  chan_mode_t [CH-1:0] mode_q;
  chan_mode_t    wmode;

  assign wmode = '{lvl: reg_wdata[MODE_LVL_BIT], b1: reg_wdata[MODE_B1_BIT], b0: reg_wdata[MODE_B0_BIT]};

  assign clr_stat = (reg_wr && reg_addr == ADDR_W'(ADDR_STAT)) ? reg_wdata[CH-1:0] : '0;
  assign clr_rise = (reg_wr && reg_addr == ADDR_W'(ADDR_RISE)) ? reg_wdata[CH-1:0] : '0;
  assign clr_fall = (reg_wr && reg_addr == ADDR_W'(ADDR_FALL)) ? reg_wdata[CH-1:0] : '0;

  pinirq_sync #(.CH(CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .lvl_o(lvl_s), .rise_o(rise_evt), .fall_o(fall_evt)
  );

  pinirq_cfg #(.CH(CH), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wmode_i(wmode), .mode_o(mode_q), .mode_wr_o(mode_wr)
  );

  for (genvar g = 0; g < CH; g++) begin : g_chan
    pinirq_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .lvl_i(lvl_s[g]), .rise_i(rise_evt[g]), .fall_i(fall_evt[g]),
      .mode_i(mode_q[g]), .mode_wr_i(mode_wr[g]),
      .clr_stat_i(clr_stat[g]), .clr_rise_i(clr_rise[g]), .clr_fall_i(clr_fall[g]),
      .stat_o(stat_q[g]), .rise_o(rise_q[g]), .fall_o(fall_q[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_STAT))      reg_rdata[CH-1:0] = stat_q;
    else if (reg_addr == ADDR_W'(ADDR_RISE)) reg_rdata[CH-1:0] = rise_q;
    else if (reg_addr == ADDR_W'(ADDR_FALL)) reg_rdata[CH-1:0] = fall_q;
    else begin
      for (int i = 0; i < CH; i++) begin
        if (reg_addr == ADDR_W'(ADDR_MODE + i)) begin
          reg_rdata[MODE_LVL_BIT] = mode_q[i].lvl;
          reg_rdata[MODE_B1_BIT]  = mode_q[i].b1;
          reg_rdata[MODE_B0_BIT]  = mode_q[i].b0;
        end
      end
    end
  end

  assign irq_o = stat_q;
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk
  import pinirq_pkg::*;
#(
  parameter int CH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CH-1:0]       lvl_s,
  input logic [CH-1:0]       rise_evt,
  input chan_mode_t [CH-1:0] mode_q,
  input logic [CH-1:0]       mode_wr,
  input logic [CH-1:0]       clr_stat,
  input logic [CH-1:0]       clr_fall,
  input logic [CH-1:0]       irq_o,
  input logic [CH-1:0]       rise_q,
  input logic [CH-1:0]       fall_q
);
  for (genvar g = 0; g < CH; g++) begin : g_chk
    // R8
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[g].lvl && !mode_q[g].b1 && !mode_q[g].b0) |=> !irq_o[g]);

    // R7
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[g].lvl && !mode_wr[g]) |=> (irq_o[g] == $past(mode_q[g].b1 ? lvl_s[g] : !lvl_s[g])));

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[g].lvl && (mode_q[g].b0 || mode_q[g].b1) && irq_o[g] && !clr_stat[g] && !mode_wr[g])
      |=> irq_o[g]);

    // R9
    rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[g].lvl && mode_q[g].b0 && rise_evt[g]) |=> rise_q[g]);

    // R5
    fall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_q[g] && !clr_fall[g]) |=> fall_q[g]);
  end
endmodule

bind pinirq_detector pinirq_chk #(.CH(CH)) u_pinirq_chk (
  .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .rise_evt(rise_evt),
  .mode_q(mode_q), .mode_wr(mode_wr), .clr_stat(clr_stat), .clr_fall(clr_fall),
  .irq_o(irq_o), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/test_pinirq_detector.sv
module test_pinirq_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] irq_o;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pinirq_detector i_pinirq_detector (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pin(input int ch, input logic v);
    @(negedge clk);
    pin_i[ch] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(irq_o, 8'h00, "R1 irq");
    rd(0, d); check(d, 8'h00, "R1 status");
    rd(1, d); check(d, 8'h00, "R1 rise");
    rd(2, d); check(d, 8'h00, "R1 fall");
    rd(11, d); check(d, 8'h00, "R1 mode3");
  endtask

  task automatic t_mode_rw;
    logic [7:0] d;
    wr(10, 8'hFF);
    rd(10, d); check(d, 8'h13, "R2 mode fields");
    wr(10, 8'h00);
  endtask

  task automatic t_rise;
    wr(8, 8'h01);
    pin(0, 1'b1); check(irq_o & 8'h01, 8'h01, "R3 rise sets");
    wr(0, 8'h01); check(irq_o & 8'h01, 8'h00, "R6 single clear");
    pin(0, 1'b0); check(irq_o & 8'h01, 8'h00, "R3 fall ignored");
  endtask

  task automatic t_fall_both;
    wr(9, 8'h02); wr(10, 8'h03);
    pin(1, 1'b1); check(irq_o & 8'h02, 8'h00, "R4 fall mode ignores rise");
    pin(1, 1'b0); check(irq_o & 8'h02, 8'h02, "R4 fall mode sets");
    pin(2, 1'b1); check(irq_o & 8'h04, 8'h04, "R4 both rise");
    wr(0, 8'h04);
    pin(2, 1'b0); check(irq_o & 8'h04, 8'h04, "R4 both fall");
  endtask

  task automatic t_flags;
    logic [7:0] d;
    rd(1, d); check(d, 8'h05, "R5 rise flags");
    rd(2, d); check(d, 8'h06, "R5 fall flags");
    wr(1, 8'h01);
    rd(1, d); check(d, 8'h04, "R5 w1c rise");
    wr(1, 8'hFF); wr(2, 8'hFF);
    rd(1, d); check(d, 8'h00, "R5 rise cleared");
    rd(2, d); check(d, 8'h00, "R5 fall cleared");
  endtask

  task automatic t_clear_all;
    wr(0, 8'hFF);
    pin(0, 1'b1); pin(2, 1'b1);
    check(irq_o, 8'h05, "R6 two pending");
    wr(0, 8'hFF); check(irq_o, 8'h00, "R6 clear all");
  endtask

  task automatic t_level;
    wr(12, 8'h12);
    pin(4, 1'b0); check(irq_o & 8'h10, 8'h00, "R7 high mode low pin");
    pin(4, 1'b1); check(irq_o & 8'h10, 8'h10, "R7 high mode high pin");
    wr(0, 8'h10); check(irq_o & 8'h10, 8'h10, "R7 clear ignored");
    pin(4, 1'b0); check(irq_o & 8'h10, 8'h00, "R7 follows low");
    wr(13, 8'h10);
    @(negedge clk);
    check(irq_o & 8'h20, 8'h20, "R7 low mode");
    wr(0, 8'h20); check(irq_o & 8'h20, 8'h20, "R7 low clear ignored");
  endtask

  task automatic t_none;
    logic [7:0] d;
    pin(6, 1'b1); check(irq_o & 8'h40, 8'h00, "R8 no irq rise");
    pin(6, 1'b0); check(irq_o & 8'h40, 8'h00, "R8 no irq fall");
    rd(1, d); check(d & 8'h40, 8'h00, "R8 no rise flag");
    rd(2, d); check(d & 8'h40, 8'h00, "R8 no fall flag");
  endtask

  task automatic collide(input int ch, input logic [3:0] a);
    @(negedge clk);
    pin_i[ch] = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = 8'hFF;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_collision;
    logic [7:0] d;
    wr(15, 8'h01);
    collide(7, 4'd0);
    check(irq_o & 8'h80, 8'h80, "R9 status edge wins");
    pin(7, 1'b0);
    wr(1, 8'hFF);
    collide(7, 4'd1);
    rd(1, d); check(d & 8'h80, 8'h80, "R9 rise flag edge wins");
  endtask

  task automatic t_mode_clear;
    check(irq_o & 8'h80, 8'h80, "R10 pending before");
    wr(15, 8'h01);
    check(irq_o & 8'h80, 8'h00, "R10 mode write clears");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_rw();
    t_rise();
    t_fall_both();
    t_flags();
    t_clear_all();
    t_level();
    t_none();
    t_collision();
    t_mode_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule